// File: doc/BRIEF.md
# Modem Status Unit

This block tracks the four active-low modem handshake inputs of one serial channel: clear-to-send, data-set-ready, ring and carrier-detect. Each pin passes through a two-flop synchroniser. The inverted, active-high level of each line appears in the upper nibble of an 8-bit status word. The lower nibble holds sticky change flags. A modem interrupt request is raised while any change flag is set and the interrupt is enabled. In loopback mode the four levels are taken from the channel's own modem-control bits, and the pins are ignored.

The host reads the status word from `msr_rd_data`, which is always valid. It pulses `rd_en` for one cycle to signal that the word has been consumed. That clock edge clears every change flag except one whose event is detected in the same cycle. There is no data stream at this block's edge, so there is no valid/ready pair. The read strobe is a plain control pin and cannot be back-pressured.

The block also drives `tx_pause` for automatic clear-to-send flow control. The transmitter asserts `char_boundary` while it is idle or has just sent a stop bit. The pause level is updated only on those cycles, so a frame that has started is always finished.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, with all four pins held high, `msr_rd_data` reads 0x00 and `irq` and `tx_pause` are 0.
- R2: Outside loopback, status bits 4, 5, 6 and 7 equal the inverse of the synchronised clear-to-send, data-set-ready, ring and carrier-detect pins. A pin change is visible two clock edges after it is applied.
- R3: Bits 0 (clear-to-send), 1 (data-set-ready) and 3 (carrier-detect) are change flags. Each one sets when its selected level changes in either direction, and stays set until a read.
- R4: Bit 2 sets only when the ring pin rises from 0 to 1 (status bit 6 goes from 1 to 0). A falling ring pin leaves bit 2 clear.
- R5: A cycle with `rd_en` high clears all four change flags at the next edge. A flag whose event is detected at that same edge ends up set.
- R6: `irq` is 1 exactly when `msi_en` is 1 and at least one change flag is set.
- R7: With `loop_en` high, bits 4, 5, 6 and 7 take `mcr_ctrl[1]`, `mcr_ctrl[0]`, `mcr_ctrl[2]` and `mcr_ctrl[3]`, and the pins have no effect on the status word.
- R8: Switching `loop_en` in either direction sets the change flags of every line whose selected level differs across the switch, using the same edge rules as R3 and R4.
- R9: Flow control is active only when both `auto_cts_en` and `mcr_ctrl[2]` are 1. When it is inactive, `tx_pause` is 0 from the next edge onward.
- R10: While flow control is active, `tx_pause` changes only at an edge where `char_boundary` is 1. It then becomes 1 if the selected clear-to-send level is inactive (pin high), and 0 if it is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_pin | input | 1 | Ring pin, active low, asynchronous |
| cd_n_pin | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Internal loopback select |
| mcr_ctrl | input | 4 | Modem-control bits: [0] DTR, [1] RTS, [2] aux/flow select, [3] aux 2 |
| msi_en | input | 1 | Modem-status interrupt enable |
| auto_cts_en | input | 1 | Automatic clear-to-send flow control enable |
| char_boundary | input | 1 | Transmitter is at a character boundary |
| rd_en | input | 1 | One-cycle read strobe, clears change flags |
| msr_rd_data | output | 8 | Status word: [7:4] levels, [3:0] change flags |
| irq | output | 1 | Modem-status interrupt request |
| tx_pause | output | 1 | Hold the transmitter at the next character boundary |

## Verification
The assertions assume that `loop_en`, `mcr_ctrl`, `msi_en`, `auto_cts_en`, `char_boundary` and `rd_en` are synchronous to `clk`. Only the four pins may change at any time. They also assume the pins rest high through reset, so no false change flag appears when reset is released. The bench meets both assumptions by driving every input just after the falling edge. It waits at least four edges after a pin change before it compares a status word, except in the same-cycle read case, which is placed deliberately at the second edge.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES       = 4;
  localparam int SYNC_DEPTH  = 2;
  localparam int MCR_W       = 4;
  localparam int WORD_W      = 2 * LINES;

  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_CD  = 3;

  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_AUX1 = 2;
  localparam int MC_AUX2 = 3;

  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t level,
  input  logic      rd_en,
  output line_vec_t flags
);
  line_vec_t prev_level;
  line_vec_t event_hit;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_evt
      if (i == LN_RI) begin : g_trail
        // ring delta: status falls, i.e. the active-low pin rises
        assign event_hit[i] = prev_level[i] & ~level[i];
      end else begin : g_any
        assign event_hit[i] = prev_level[i] ^ level[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_level <= '0;
      flags      <= '0;
    end else begin
      prev_level <= level;
      flags      <= (flags & ~{LINES{rd_en}}) | event_hit;
    end
  end

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && flags[LN_CTS]) |=> flags[LN_CTS]);

  assert_ri_lead_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_level[LN_RI] && level[LN_RI] && (rd_en || !flags[LN_RI])) |=> !flags[LN_RI]);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (level == prev_level)) |=> (flags == '0));
endmodule

// File: rtl/msr_flow.sv
module msr_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_cts_en,
  input  logic flow_sel,
  input  logic cts_active,
  input  logic char_boundary,
  output logic tx_pause
);
  logic flow_on;
  assign flow_on = auto_cts_en & flow_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tx_pause <= 1'b0;
    else if (!flow_on)      tx_pause <= 1'b0;
    else if (char_boundary) tx_pause <= ~cts_active;
  end

  assert_flow_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(auto_cts_en && flow_sel) |=> !tx_pause);

  assert_hold_mid_char_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && flow_sel && !char_boundary) |=> $stable(tx_pause));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n_pin,
  input  logic              dsr_n_pin,
  input  logic              ri_n_pin,
  input  logic              cd_n_pin,
  input  logic              loop_en,
  input  logic [MCR_W-1:0]  mcr_ctrl,
  input  logic              msi_en,
  input  logic              auto_cts_en,
  input  logic              char_boundary,
  input  logic              rd_en,
  output logic [WORD_W-1:0] msr_rd_data,
  output logic              irq,
  output logic              tx_pause
);
  line_vec_t pins_raw, pins_sync, pin_level, loop_level, sel_level, flags;

  assign pins_raw[LN_CTS] = cts_n_pin;
  assign pins_raw[LN_DSR] = dsr_n_pin;
  assign pins_raw[LN_RI]  = ri_n_pin;
  assign pins_raw[LN_CD]  = cd_n_pin;

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_raw), .sync_out(pins_sync));

  assign pin_level = ~pins_sync;

  assign loop_level[LN_CTS] = mcr_ctrl[MC_RTS];
  assign loop_level[LN_DSR] = mcr_ctrl[MC_DTR];
  assign loop_level[LN_RI]  = mcr_ctrl[MC_AUX1];
  assign loop_level[LN_CD]  = mcr_ctrl[MC_AUX2];

  assign sel_level = loop_en ? loop_level : pin_level;

  msr_delta u_delta (
    .clk(clk), .rst_n(rst_n), .level(sel_level), .rd_en(rd_en), .flags(flags));

  msr_flow u_flow (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en),
    .flow_sel(mcr_ctrl[MC_AUX1]), .cts_active(sel_level[LN_CTS]),
    .char_boundary(char_boundary), .tx_pause(tx_pause));

  assign msr_rd_data = {sel_level, flags};
  assign irq         = msi_en & (|flags);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msi_en && (msr_rd_data[LINES-1:0] != '0)));

  assert_loop_ignores_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && $stable(mcr_ctrl)) |=> (!loop_en || !$stable(mcr_ctrl) ||
                                        $stable(msr_rd_data[WORD_W-1:LINES])));
endmodule

// File: tb/modem_status_unit_tb.sv
`timescale 1ns/1ps
module modem_status_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n_pin = 1'b1, dsr_n_pin = 1'b1, ri_n_pin = 1'b1, cd_n_pin = 1'b1;
  logic loop_en = 1'b0;
  logic [3:0] mcr_ctrl = 4'h0;
  logic msi_en = 1'b1, auto_cts_en = 1'b0, char_boundary = 1'b0, rd_en = 1'b0;
  logic [7:0] msr_rd_data;
  logic irq, tx_pause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  event rd_sample;

  always #2 clk = ~clk;

  modem_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cts_n_pin(cts_n_pin), .dsr_n_pin(dsr_n_pin),
    .ri_n_pin(ri_n_pin), .cd_n_pin(cd_n_pin), .loop_en(loop_en),
    .mcr_ctrl(mcr_ctrl), .msi_en(msi_en), .auto_cts_en(auto_cts_en),
    .char_boundary(char_boundary), .rd_en(rd_en), .msr_rd_data(msr_rd_data),
    .irq(irq), .tx_pause(tx_pause));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected word when a read is sampled
  always @(rd_sample) begin
    if (exp_q.size() == 0) begin
      chk("scoreboard underflow", 8'h01, 8'h00);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, msr_rd_data, e);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: starts and ends at a falling edge
  task automatic read_exp(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1;
    #1 -> rd_sample;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tx_pause", {7'd0, tx_pause}, 8'h00);
    read_exp(8'h00, "R1 status after reset");

    // R2 R3 R6 clear-to-send falling and rising
    cts_n_pin = 1'b0; wait_cyc(4);
    #1 chk("R6 irq with delta", {7'd0, irq}, 8'h01);
    @(negedge clk);
    read_exp(8'h11, "R2 R3 cts assert");
    read_exp(8'h10, "R5 flags cleared");
    #1 chk("R6 irq after clear", {7'd0, irq}, 8'h00);
    @(negedge clk);
    cts_n_pin = 1'b1; wait_cyc(4);
    read_exp(8'h01, "R3 cts release");

    // R3 data-set-ready
    dsr_n_pin = 1'b0; wait_cyc(4);
    read_exp(8'h22, "R2 R3 dsr assert");
    dsr_n_pin = 1'b1; wait_cyc(4);
    read_exp(8'h02, "R3 dsr release");

    // R4 ring: only the trailing edge flags
    ri_n_pin = 1'b0; wait_cyc(4);
    read_exp(8'h40, "R4 ring start no delta");
    ri_n_pin = 1'b1; wait_cyc(4);
    read_exp(8'h04, "R4 ring end delta");

    // R3 R6 carrier-detect and interrupt enable
    cd_n_pin = 1'b0; wait_cyc(4);
    msi_en = 1'b0;
    #1 chk("R6 irq disabled", {7'd0, irq}, 8'h00);
    msi_en = 1'b1;
    #1 chk("R6 irq enabled", {7'd0, irq}, 8'h01);
    @(negedge clk);
    read_exp(8'h88, "R2 R3 cd assert");
    cd_n_pin = 1'b1; wait_cyc(4);
    read_exp(8'h08, "R3 cd release");

    // R5 read coinciding with a new event
    cts_n_pin = 1'b0; wait_cyc(4);
    dsr_n_pin = 1'b0; wait_cyc(2);
    read_exp(8'h31, "R5 read at event edge");
    read_exp(8'h32, "R5 concurrent event kept");
    cts_n_pin = 1'b1; dsr_n_pin = 1'b1; wait_cyc(4);
    read_exp(8'h03, "R3 both release");

    // R7 R8 loopback
    mcr_ctrl = 4'b1111; loop_en = 1'b1; wait_cyc(2);
    read_exp(8'hFB, "R7 R8 enter loopback");
    mcr_ctrl = 4'b0001; wait_cyc(2);
    read_exp(8'h2D, "R7 loop bit mapping");
    cts_n_pin = 1'b0; wait_cyc(4);
    read_exp(8'h20, "R7 pins ignored in loop");
    loop_en = 1'b0; wait_cyc(2);
    read_exp(8'h13, "R8 leave loopback");
    cts_n_pin = 1'b1; mcr_ctrl = 4'b0000; wait_cyc(4);
    read_exp(8'h01, "R3 cts release after loop");

    // R9 R10 flow control
    cts_n_pin = 1'b0; mcr_ctrl = 4'b0100; auto_cts_en = 1'b1; wait_cyc(4);
    char_boundary = 1'b1; wait_cyc(1); char_boundary = 1'b0;
    #1 chk("R10 clear to send", {7'd0, tx_pause}, 8'h00);
    @(negedge clk);
    cts_n_pin = 1'b1; wait_cyc(6);
    #1 chk("R10 mid-char no pause", {7'd0, tx_pause}, 8'h00);
    @(negedge clk);
    char_boundary = 1'b1; wait_cyc(1); char_boundary = 1'b0;
    #1 chk("R10 pause at boundary", {7'd0, tx_pause}, 8'h01);
    @(negedge clk);
    cts_n_pin = 1'b0; wait_cyc(6);
    #1 chk("R10 pause held mid-char", {7'd0, tx_pause}, 8'h01);
    @(negedge clk);
    char_boundary = 1'b1; wait_cyc(1); char_boundary = 1'b0;
    #1 chk("R10 resume at boundary", {7'd0, tx_pause}, 8'h00);
    @(negedge clk);
    cts_n_pin = 1'b1; char_boundary = 1'b1; mcr_ctrl = 4'b0000; wait_cyc(6);
    #1 chk("R9 select bit off", {7'd0, tx_pause}, 8'h00);
    @(negedge clk);
    mcr_ctrl = 4'b0100; auto_cts_en = 1'b0; wait_cyc(3);
    #1 chk("R9 auto enable off", {7'd0, tx_pause}, 8'h00);
    @(negedge clk);
    auto_cts_en = 1'b1; wait_cyc(2);
    #1 chk("R9 R10 both on pauses", {7'd0, tx_pause}, 8'h01);

    if (exp_q.size() != 0) chk("scoreboard leftover", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule